// File: doc/BRIEF.md
# Stack Machine Instruction Sequencer

This block fetches and executes 16-bit instructions for a small processor that keeps its working values on a stack in memory. Every instruction word carries a predicate, two operand-source selectors, a flag-update enable, an output routing and a 5-bit command. The sequencer holds the instruction pointer, stack pointer, base pointer and a three-bit flag register. It gathers the two operands one after the other, runs the command, and then discards the result, pushes it, or uses it as an absolute or relative jump target.

All traffic goes through one synchronous memory port. A request is issued in one cycle and read data is returned in the next cycle. A port access is either a 16-bit little-endian word (low byte at the lower address) or a single byte carried on data bits 7:0. The block executes one instruction at a time over several cycles and pulses `retired` in the cycle after each instruction completes. Two reserved commands stop execution for good, one raising a sticky trap flag and the other a sticky breakpoint flag, until the next reset.

Top module: `stack_seq`

## Requirements
- R1: Reset state: ip, sp and bp are 0x0000 and flags are 3'b000. The outputs halted, trap, brk and retired are low.
- R2: Instruction word fields: bits 2:0 condition, 4:3 source of operand A, 6:5 source of operand B, 7 flag-update enable, 9:8 output routing, 14:10 command, bit 15 ignored. Fetching an instruction advances ip by 2.
- R3: Operand source codes: 0 yields 0x0000. 1 reads the immediate word at ip and adds 2 to ip. 2 reads the word at sp without moving sp. 3 reads the word at sp and then adds 2 to sp. Operand A is resolved before operand B. Command 0 returns operand A.
- R4: Output routing codes: 0 discards the result. 1 subtracts 2 from sp and then writes the result as a word at the new sp. 2 loads the result into ip. 3 adds the result to ip after all immediates of the instruction have been consumed.
- R5: Condition codes against flags (bit 0 zero Z, bit 1 negative N, bit 2 carry C): 0 always; 1 Z; 2 not Z; 3 neither Z nor N; 4 N; 5 not N; 6 Z or N; 7 C.
- R6: When the condition is false, ip advances past the instruction word and past one word for each immediate source. No stack word is consumed, nothing is written and no flag changes.
- R7: Frame commands: 2 returns the word at bp+2*A. 3 writes B as a word at bp+2*A and returns B. 1 returns ip+2*A, where ip already points past every immediate.
- R8: Memory commands: 6 returns the byte at address A, zero-extended. 7 returns the word at A. 4 writes the low byte of B to A and returns that byte zero-extended. 5 writes the word B to A and returns B.
- R9: Register commands: 14 and 12 return sp and bp. 15 and 13 load A into sp and bp and return A. 10 returns flags zero-extended. 11 sets flags to (flags & B[2:0]) | (A[2:0] & ~B[2:0]) and returns the new value zero-extended.
- R10: Arithmetic commands: 16 add, with C set to the carry out. 17 subtract A-B, with C set on borrow. 18 multiply (low 16 bits). 19 divide and 20 remainder; divide by zero gives 0xFFFF and remainder by zero gives A. 21 and, 22 or, 23 xor, 24 not A, 25 sign-extend A[7:0]. Single-bit shifts of A: 26 rotate left, 27 rotate right, 29 arithmetic right, 30 logical left, 31 logical right. 28 swaps the two bytes of A.
- R11: When the flag-update bit is set, N takes bit 15 of the result and Z is set exactly when the result is 0x0000. The new flags are seen by the next instruction's condition.
- R12: A taken command 8 sets trap and a taken command 9 sets brk. The flag stays set, halted rises, and no further memory request or retirement occurs until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req | output | 1 | Memory access request this cycle |
| mem_we | output | 1 | Request is a write |
| mem_wide | output | 1 | 1 = 16-bit little-endian word, 0 = byte on bits 7:0 |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| ip | output | 16 | Instruction pointer |
| sp | output | 16 | Stack pointer |
| bp | output | 16 | Base pointer |
| flags | output | 3 | {carry, negative, zero} |
| retired | output | 1 | Pulses after each instruction completes or is skipped |
| halted | output | 1 | Execution stopped by a trap or breakpoint command |
| trap | output | 1 | Sticky trap flag |
| brk | output | 1 | Sticky breakpoint flag |

## Verification
Two pairs of effects can land on the same instruction. In one, the flag-update bit and the push output complete in the same step. In the other, two stack pops are followed by a push, so sp moves three times within one instruction. The bench provokes both with a flag-setting add that pops two operands and pushes its sum, and with an xor that pops two and pushes. Each is followed at once by instructions conditioned on the new flags. A behavioural instruction-level model, kept independently in the bench, is stepped on every retirement pulse. After each step the bench compares ip, sp, bp, flags and the whole memory image with the model, so a wrong order between the sp update and the write, or a stale flag, shows up at that instruction.

// File: rtl/stack_seq.sv
module stack_seq #(
  parameter logic [15:0] SP_INIT = 16'h0000,
  parameter logic [15:0] BP_INIT = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic        mem_req,
  output logic        mem_we,
  output logic        mem_wide,
  output logic [15:0] mem_addr,
  output logic [15:0] mem_wdata,
  input  logic [15:0] mem_rdata,
  output logic [15:0] ip,
  output logic [15:0] sp,
  output logic [15:0] bp,
  output logic [2:0]  flags,
  output logic        retired,
  output logic        halted,
  output logic        trap,
  output logic        brk
);

  typedef enum logic [2:0] {S_FETCH, S_DEC, S_IN, S_INW, S_EXEC, S_MEMW, S_OUT, S_HALT} st_t;

  st_t         st;
  logic [14:0] ir;
  logic [15:0] v0, v1, res, alu, nimm;
  logic        sel, zf, nf, cf, alu_c, go;
  logic [2:0]  fr_new;

  assign flags  = {cf, nf, zf};
  assign halted = (st == S_HALT);

  wire [4:0]  cmd    = ir[14:10];
  wire [1:0]  outsel = ir[9:8];
  wire        upd    = ir[7];
  wire [1:0]  src    = sel ? ir[6:5] : ir[4:3];
  wire [15:0] fofs   = bp + {v0[14:0], 1'b0};

  assign nimm   = ((mem_rdata[4:3] == 2'd1) ? 16'd2 : 16'd0) +
                  ((mem_rdata[6:5] == 2'd1) ? 16'd2 : 16'd0);
  assign fr_new = (flags & v1[2:0]) | (v0[2:0] & ~v1[2:0]);

  always_comb begin
    case (mem_rdata[2:0])
      3'd0:    go = 1'b1;
      3'd1:    go = zf;
      3'd2:    go = !zf;
      3'd3:    go = !zf && !nf;
      3'd4:    go = nf;
      3'd5:    go = !nf;
      3'd6:    go = zf || nf;
      default: go = cf;
    endcase
  end

  always_comb begin
    alu   = 16'h0000;
    alu_c = cf;
    case (cmd)
      5'd0:    alu = v0;
      5'd1:    alu = ip + {v0[14:0], 1'b0};
      5'd3:    alu = v1;
      5'd4:    alu = {8'h00, v1[7:0]};
      5'd5:    alu = v1;
      5'd10:   alu = {13'h0, flags};
      5'd11:   alu = {13'h0, fr_new};
      5'd12:   alu = bp;
      5'd13:   alu = v0;
      5'd14:   alu = sp;
      5'd15:   alu = v0;
      5'd16:   {alu_c, alu} = {1'b0, v0} + {1'b0, v1};
      5'd17:   {alu_c, alu} = {1'b0, v0} - {1'b0, v1};
      5'd18:   alu = v0 * v1;
      5'd19:   alu = (v1 == 16'h0) ? 16'hFFFF : v0 / v1;
      5'd20:   alu = (v1 == 16'h0) ? v0 : v0 % v1;
      5'd21:   alu = v0 & v1;
      5'd22:   alu = v0 | v1;
      5'd23:   alu = v0 ^ v1;
      5'd24:   alu = ~v0;
      5'd25:   alu = {{8{v0[7]}}, v0[7:0]};
      5'd26:   alu = {v0[14:0], v0[15]};
      5'd27:   alu = {v0[0], v0[15:1]};
      5'd28:   alu = {v0[7:0], v0[15:8]};
      5'd29:   alu = {v0[15], v0[15:1]};
      5'd30:   alu = {v0[14:0], 1'b0};
      5'd31:   alu = {1'b0, v0[15:1]};
      default: alu = 16'h0000;
    endcase
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_wide  = 1'b1;
    mem_addr  = 16'h0000;
    mem_wdata = 16'h0000;
    case (st)
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = ip;
      end
      S_IN: begin
        mem_req  = (src != 2'd0);
        mem_addr = (src == 2'd1) ? ip : sp;
      end
      S_EXEC: begin
        case (cmd)
          5'd2: begin mem_req = 1'b1; mem_addr = fofs; end
          5'd3: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = fofs; mem_wdata = v1; end
          5'd4: begin mem_req = 1'b1; mem_we = 1'b1; mem_wide = 1'b0; mem_addr = v0; mem_wdata = {8'h00, v1[7:0]}; end
          5'd5: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = v0; mem_wdata = v1; end
          5'd6: begin mem_req = 1'b1; mem_wide = 1'b0; mem_addr = v0; end
          5'd7: begin mem_req = 1'b1; mem_addr = v0; end
          default: ;
        endcase
      end
      S_OUT: begin
        if (outsel == 2'd1) begin
          mem_req   = 1'b1;
          mem_we    = 1'b1;
          mem_addr  = sp - 16'd2;
          mem_wdata = res;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_FETCH;
      ip      <= 16'h0000;
      sp      <= SP_INIT;
      bp      <= BP_INIT;
      {cf, nf, zf} <= 3'b000;
      trap    <= 1'b0;
      brk     <= 1'b0;
      retired <= 1'b0;
      ir      <= 15'h0;
      v0      <= 16'h0;
      v1      <= 16'h0;
      res     <= 16'h0;
      sel     <= 1'b0;
    end else begin
      retired <= 1'b0;
      case (st)
        S_FETCH: st <= S_DEC;
        S_DEC: begin
          ir  <= mem_rdata[14:0];
          sel <= 1'b0;
          if (go) begin
            ip <= ip + 16'd2;
            st <= S_IN;
          end else begin
            ip      <= ip + 16'd2 + nimm;
            retired <= 1'b1;
            st      <= S_FETCH;
          end
        end
        S_IN: begin
          case (src)
            2'd0: begin
              if (sel) begin v1 <= 16'h0; st <= S_EXEC; end
              else begin v0 <= 16'h0; sel <= 1'b1; end
            end
            2'd1: begin ip <= ip + 16'd2; st <= S_INW; end
            2'd2: st <= S_INW;
            default: begin sp <= sp + 16'd2; st <= S_INW; end
          endcase
        end
        S_INW: begin
          if (sel) begin v1 <= mem_rdata; st <= S_EXEC; end
          else begin v0 <= mem_rdata; sel <= 1'b1; st <= S_IN; end
        end
        S_EXEC: begin
          res <= alu;
          st  <= S_OUT;
          case (cmd)
            5'd2, 5'd6, 5'd7: st <= S_MEMW;
            5'd8:  begin trap <= 1'b1; retired <= 1'b1; st <= S_HALT; end
            5'd9:  begin brk  <= 1'b1; retired <= 1'b1; st <= S_HALT; end
            5'd11: {cf, nf, zf} <= fr_new;
            5'd13: bp <= v0;
            5'd15: sp <= v0;
            5'd16, 5'd17: cf <= alu_c;
            default: ;
          endcase
        end
        S_MEMW: begin
          res <= (cmd == 5'd6) ? {8'h00, mem_rdata[7:0]} : mem_rdata;
          st  <= S_OUT;
        end
        S_OUT: begin
          if (upd) begin
            nf <= res[15];
            zf <= (res == 16'h0000);
          end
          case (outsel)
            2'd1: sp <= sp - 16'd2;
            2'd2: ip <= res;
            2'd3: ip <= ip + res;
            default: ;
          endcase
          retired <= 1'b1;
          st      <= S_FETCH;
        end
        default: st <= S_HALT;
      endcase
    end
  end

  // R12
  trap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) trap |=> trap);
  // R12
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) halted |-> !mem_req);
  // R3
  pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IN && src == 2'd3) |=> sp == $past(sp) + 16'd2);
  // R4
  push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OUT && outsel == 2'd1) |=> sp == $past(mem_addr));
  // R11
  flag_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_OUT && upd) |=> (flags[0] == ($past(res) == 16'h0000)) && (flags[1] == $past(res[15])));
  // R6
  skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DEC && !go) |=> (st == S_FETCH) && (sp == $past(sp)) && (flags == $past(flags)));

endmodule

// File: tb/sim_stack_seq.sv
module sim_stack_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mem_req, mem_we, mem_wide, retired, halted, trap, brk;
  logic [15:0] mem_addr, mem_wdata, ip, sp, bp;
  logic [15:0] mem_rdata = 16'h0;
  logic [2:0]  flags;

  always #4 clk = ~clk;

  stack_seq u0 (.clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we), .mem_wide(mem_wide),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ip(ip), .sp(sp), .bp(bp),
    .flags(flags), .retired(retired), .halted(halted), .trap(trap), .brk(brk));

  logic [7:0] dmem [0:4095];
  logic [7:0] mm   [0:4095];
  int nchk = 0, nbad = 0, pc;

  logic [15:0] a1w;
  assign a1w = mem_addr + 16'd1;
  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) begin
        dmem[mem_addr[11:0]] <= mem_wdata[7:0];
        if (mem_wide) dmem[a1w[11:0]] <= mem_wdata[15:8];
      end else
        mem_rdata <= mem_wide ? {dmem[a1w[11:0]], dmem[mem_addr[11:0]]} : {8'h00, dmem[mem_addr[11:0]]};
    end
  end

  localparam logic [1:0] Z = 0, IM = 1, PK = 2, PP = 3;
  localparam logic [1:0] OD = 0, OP = 1, OJ = 2, OR = 3;

  logic [15:0] mip, msp, mbp;
  logic mz, mn, mc, mtrap, mbrk;
  string mreq;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] rd16(input logic [15:0] a);
    logic [15:0] b = a + 16'd1;
    return {mm[b[11:0]], mm[a[11:0]]};
  endfunction

  task automatic wr16(input logic [15:0] a, input logic [15:0] v);
    logic [15:0] b = a + 16'd1;
    mm[a[11:0]] = v[7:0];
    mm[b[11:0]] = v[15:8];
  endtask

  task automatic opnd(input logic [1:0] s, output logic [15:0] v);
    case (s)
      0: v = 16'h0;
      1: begin v = rd16(mip); mip += 16'd2; end
      2: v = rd16(msp);
      default: begin v = rd16(msp); msp += 16'd2; end
    endcase
  endtask

  task automatic mstep();
    logic [15:0] w, v0, v1, r;
    logic [2:0] nf3;
    bit ok;
    int s;
    w = rd16(mip);
    mip += 16'd2;
    case (w[2:0])
      0: ok = 1;
      1: ok = mz;
      2: ok = !mz;
      3: ok = !mz && !mn;
      4: ok = mn;
      5: ok = !mn;
      6: ok = mz || mn;
      default: ok = mc;
    endcase
    if (!ok) begin
      mip += ((w[4:3] == 1) ? 16'd2 : 16'd0) + ((w[6:5] == 1) ? 16'd2 : 16'd0);
      mreq = "R6 R5";
      return;
    end
    opnd(w[4:3], v0);
    opnd(w[6:5], v1);
    r = 16'h0;
    case (w[14:10])
      0: begin r = v0; mreq = "R3"; end
      1: begin r = mip + 16'(v0 * 2); mreq = "R7"; end
      2: begin r = rd16(mbp + 16'(v0 * 2)); mreq = "R7"; end
      3: begin wr16(mbp + 16'(v0 * 2), v1); r = v1; mreq = "R7"; end
      4: begin mm[v0[11:0]] = v1[7:0]; r = v1 & 16'h00FF; mreq = "R8"; end
      5: begin wr16(v0, v1); r = v1; mreq = "R8"; end
      6: begin r = {8'h00, mm[v0[11:0]]}; mreq = "R8"; end
      7: begin r = rd16(v0); mreq = "R8"; end
      8: begin mtrap = 1; mreq = "R12"; return; end
      9: begin mbrk = 1; mreq = "R12"; return; end
      10: begin r = {13'h0, mc, mn, mz}; mreq = "R9"; end
      11: begin nf3 = ({mc, mn, mz} & v1[2:0]) | (v0[2:0] & ~v1[2:0]); {mc, mn, mz} = nf3; r = {13'h0, nf3}; mreq = "R9"; end
      12: begin r = mbp; mreq = "R9"; end
      13: begin mbp = v0; r = v0; mreq = "R9"; end
      14: begin r = msp; mreq = "R9"; end
      15: begin msp = v0; r = v0; mreq = "R9"; end
      16: begin s = int'(v0) + int'(v1); r = s[15:0]; mc = (s > 65535); mreq = "R10"; end
      17: begin s = int'(v0) - int'(v1); r = s[15:0]; mc = (v0 < v1); mreq = "R10"; end
      18: begin s = int'(v0) * int'(v1); r = s[15:0]; mreq = "R10"; end
      19: begin r = (v1 == 0) ? 16'hFFFF : v0 / v1; mreq = "R10"; end
      20: begin r = (v1 == 0) ? v0 : v0 % v1; mreq = "R10"; end
      21: begin r = v0 & v1; mreq = "R10"; end
      22: begin r = v0 | v1; mreq = "R10"; end
      23: begin r = v0 ^ v1; mreq = "R10"; end
      24: begin r = ~v0; mreq = "R10"; end
      25: begin r = v0[7] ? (16'hFF00 | (v0 & 16'h00FF)) : (v0 & 16'h00FF); mreq = "R10"; end
      26: begin r = (v0 << 1) | (v0 >> 15); mreq = "R10"; end
      27: begin r = (v0 >> 1) | (v0 << 15); mreq = "R10"; end
      28: begin r = (v0 << 8) | (v0 >> 8); mreq = "R10"; end
      29: begin r = (v0 >> 1) | (v0 & 16'h8000); mreq = "R10"; end
      30: begin r = v0 << 1; mreq = "R10"; end
      default: begin r = v0 >> 1; mreq = "R10"; end
    endcase
    if (w[2:0] != 0) mreq = {mreq, " R5"};
    if (w[7]) begin mn = r[15]; mz = (r == 16'h0); end
    case (w[9:8])
      1: begin msp -= 16'd2; wr16(msp, r); end
      2: mip = r;
      3: mip += r;
      default: ;
    endcase
  endtask

  task automatic put(input logic [15:0] w);
    mm[pc] = w[7:0]; mm[pc + 1] = w[15:8];
    dmem[pc] = w[7:0]; dmem[pc + 1] = w[15:8];
    pc += 2;
  endtask

  task automatic op(input logic [2:0] c, input logic [1:0] a, input logic [1:0] b, input bit f,
                    input logic [1:0] o, input logic [4:0] cmd);
    put({1'b0, cmd, o, f, b, a, c});
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) begin mm[i] = 8'h00; dmem[i] = 8'h00; end
    pc = 0;
  endtask

  task automatic cmp_state();
    int diff = 0;
    check(ip == mip, {mreq, " R2 R4"}, "ip", ip, mip);
    check(sp == msp, {mreq, " R3 R4"}, "sp", sp, msp);
    check(bp == mbp, mreq, "bp", bp, mbp);
    check(flags == {mc, mn, mz}, {mreq, " R11"}, "flags", flags, {mc, mn, mz});
    check(trap == mtrap && brk == mbrk, {mreq, " R12"}, "trap/brk", {trap, brk}, {mtrap, mbrk});
    for (int i = 0; i < 4096; i++) if (dmem[i] !== mm[i]) diff++;
    check(diff == 0, {mreq, " R8"}, "memory bytes differing", diff, 0);
  endtask

  task automatic run_prog();
    int cyc = 0;
    rst_n = 1'b0;
    mip = 0; msp = 0; mbp = 0; {mc, mn, mz} = 3'b000; mtrap = 0; mbrk = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(ip == 0 && sp == 0 && bp == 0, "R1", "pointers", {ip, sp}, 0);
    check(flags == 0 && !halted && !trap && !brk && !retired, "R1", "flags/halt", {flags, halted, trap, brk}, 0);
    forever begin
      @(negedge clk);
      cyc++;
      if (retired) begin
        mstep();
        cmp_state();
        if (mtrap || mbrk) break;
      end
      if (cyc > 5000) begin
        check(0, "R12", "program never halted", cyc, 5000);
        break;
      end
    end
    // R12: halted stays quiet
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      check(halted && !mem_req && !retired, "R12", "halt quiet", {halted, mem_req, retired}, 3'b100);
    end
    cmp_state();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end

  initial begin
    clear_mem();
    op(0, IM, Z, 0, OD, 15); put(16'h0800);
    op(0, IM, Z, 0, OD, 13); put(16'h0600);
    op(0, IM, Z, 0, OP, 0);  put(16'h1234);
    op(0, IM, Z, 0, OP, 0);  put(16'h00F0);
    op(0, PP, PP, 1, OP, 16);
    op(4, PK, Z, 0, OP, 0);
    op(0, IM, IM, 1, OP, 17); put(16'h0001); put(16'h0002);
    op(7, IM, Z, 0, OP, 0);  put(16'hAAAA);
    op(1, PP, IM, 0, OP, 0); put(16'hCCCC);
    op(4, IM, Z, 0, OP, 0);  put(16'h0001);
    op(5, IM, Z, 0, OP, 0);  put(16'h0002);
    op(6, IM, Z, 0, OP, 0);  put(16'h0003);
    op(3, IM, Z, 0, OP, 0);  put(16'h0004);
    op(0, IM, IM, 1, OD, 16); put(16'hFFFF); put(16'h0001);
    op(1, IM, Z, 0, OP, 0);  put(16'h0002);
    op(2, IM, Z, 0, OP, 0);  put(16'h0005);
    op(3, IM, Z, 0, OP, 0);  put(16'h0006);
    op(6, IM, Z, 0, OP, 0);  put(16'h0007);
    op(5, IM, Z, 0, OP, 0);  put(16'h0008);
    op(7, IM, Z, 0, OP, 0);  put(16'h0009);
    op(0, IM, Z, 1, OD, 0);  put(16'h0005);
    op(3, IM, Z, 0, OP, 0);  put(16'h0003);
    op(0, IM, IM, 0, OP, 18); put(16'h0123); put(16'h0010);
    op(0, IM, IM, 0, OP, 19); put(16'd100);   put(16'd7);
    op(0, IM, IM, 0, OP, 20); put(16'd100);   put(16'd7);
    op(0, IM, IM, 0, OP, 19); put(16'h0055);  put(16'h0000);
    op(0, IM, IM, 0, OP, 20); put(16'h0055);  put(16'h0000);
    op(0, IM, IM, 0, OP, 21); put(16'hF0F0);  put(16'h3C3C);
    op(0, IM, IM, 0, OP, 22); put(16'hF0F0);  put(16'h3C3C);
    op(0, IM, IM, 0, OP, 23); put(16'hF0F0);  put(16'h3C3C);
    op(0, IM, Z, 1, OP, 24);  put(16'h00FF);
    op(0, IM, Z, 0, OP, 25);  put(16'h1280);
    op(0, IM, Z, 0, OP, 25);  put(16'h127F);
    op(0, IM, Z, 0, OP, 26);  put(16'h8001);
    op(0, IM, Z, 0, OP, 27);  put(16'h8001);
    op(0, IM, Z, 0, OP, 28);  put(16'h1234);
    op(0, IM, Z, 0, OP, 29);  put(16'h8004);
    op(0, IM, Z, 0, OP, 30);  put(16'hC001);
    op(0, IM, Z, 1, OP, 31);  put(16'h0001);
    op(0, IM, IM, 0, OD, 3);  put(16'h0003); put(16'hBEEF);
    op(0, IM, Z, 0, OP, 2);   put(16'h0003);
    op(0, IM, Z, 0, OP, 1);   put(16'h0001);
    op(0, IM, IM, 0, OD, 5);  put(16'h0700); put(16'hA55A);
    op(0, IM, IM, 0, OP, 4);  put(16'h0703); put(16'h1277);
    op(0, IM, Z, 0, OP, 7);   put(16'h0702);
    op(0, IM, Z, 0, OP, 6);   put(16'h0701);
    op(0, Z, Z, 0, OP, 14);
    op(0, Z, Z, 0, OP, 12);
    op(0, IM, IM, 0, OD, 17); put(16'h0000); put(16'h0001);
    op(0, IM, Z, 1, OD, 0);   put(16'h8000);
    op(0, Z, Z, 0, OP, 10);
    op(0, IM, IM, 0, OP, 11); put(16'h0001); put(16'h0002);
    op(1, IM, Z, 0, OP, 0);   put(16'h0011);
    op(0, PK, Z, 0, OP, 0);
    op(0, PP, PP, 1, OP, 23);
    op(1, IM, Z, 0, OP, 0);   put(16'h0022);
    op(0, IM, Z, 0, OJ, 0);   put(16'(pc + 4));
    op(0, Z, Z, 0, OD, 8);
    op(0, IM, Z, 0, OR, 0);   put(16'h0002);
    op(0, Z, Z, 0, OD, 8);
    op(2, IM, Z, 0, OR, 0);   put(16'h0002);
    op(0, Z, Z, 0, OD, 9);
    op(0, IM, Z, 0, OP, 0);   put(16'h0077);
    op(0, Z, Z, 0, OD, 8);
    run_prog();

    clear_mem();
    op(0, IM, Z, 0, OD, 15);  put(16'h0900);
    op(0, IM, Z, 1, OD, 0);   put(16'h0001);
    op(1, Z, Z, 0, OD, 8);
    op(4, Z, Z, 0, OD, 9);
    op(0, IM, Z, 0, OP, 0);   put(16'h5151);
    op(0, Z, Z, 0, OD, 9);
    op(0, IM, Z, 0, OP, 0);   put(16'h6262);
    run_prog();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nchk, nbad);
    $finish;
  end
endmodule